// File: doc/BRIEF.md
# Fractional Baud-Rate Clock Generator

This block turns one peripheral clock into the single-cycle timing enables a serial channel needs. A first divider stage works either as an integer reload counter, giving one pulse every (1024 − step) clocks, or as a 1024-modulus phase accumulator, giving on average step pulses per 1024 clocks. An optional divide-by-two follows. After that comes a programmable prescaler. A four-way source selector then feeds a time-quantum divider, and an oversampling divider after it produces the bit-rate enable. Two more enables are produced alongside: a shift-clock enable at half the prescaler rate and a master-clock enable at half the first-stage rate.

Configuration is supplied on plain input ports and takes effect on a write strobe. The same write clears every divider and toggle stage, so the first period after a change is a whole period measured from the write. All outputs are enables that last one clock and are synchronous to the input clock. Downstream logic uses them as clock enables and never as clocks.

Top module: `frac_baud_gen`

## Requirements
- R1: In integer mode (`cfg_frac`=0), `div_en` pulses once every 1024 − `cfg_step` clocks. The first pulse appears in the (1024 − step)-th cycle after the write edge, so step 1023 gives a pulse in every cycle and step 0 gives one pulse in every 1024.
- R2: In fractional mode (`cfg_frac`=1), `div_en` gives exactly floor(W·step/1024) pulses in the W cycles after a write. Step 0 gives no pulse at all.
- R3: With `cfg_half`=1, the prescaler input is every second `div_en` pulse. With `cfg_half`=0 it is every `div_en` pulse.
- R4: The prescaler emits one pulse per `cfg_pre`+1 input pulses. `sclk_en` is every second prescaler pulse.
- R5: `mclk_en` is every second `div_en` pulse, whatever the value of `cfg_half`.
- R6: `cfg_sel` chooses the time-quantum source: 0 is the prescaler output, 1 is the prescaler input (the prescaler is bypassed), 2 is the prescaler output halved (the same rate as `sclk_en`), and 3 is `mclk_en`. `tq_en` gives one pulse per `cfg_tq`+1 source pulses.
- R7: `bit_en` gives one pulse per `cfg_os`+1 `tq_en` pulses.
- R8: A write (`cfg_wr`=1) latches every configuration field and clears all divider and toggle state. In the cycle after the write edge no enable is high, and pulse counts then restart from zero.
- R9: Reset (`rst_n`=0, synchronous) drives every output low and loads the all-zero configuration: integer mode, step 0, no halving, prescaler 0, selector 0, time-quantum 0, oversampling 0.
- R10: Every derived enable (`mclk_en`, `sclk_en`, `tq_en`, `bit_en`) is high only in a cycle where `div_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe; latches fields and clears dividers |
| cfg_step | input | STEP_W (10) | First-stage step value |
| cfg_frac | input | 1 | 1 selects fractional accumulate mode, 0 selects integer reload mode |
| cfg_half | input | 1 | Inserts divide-by-two after the first stage |
| cfg_pre | input | PRE_W (10) | Prescaler field, divides by field + 1 |
| cfg_sel | input | 2 | Time-quantum source select (0 to 3, see R6) |
| cfg_tq | input | TQ_W (6) | Time-quantum field, divides by field + 1 |
| cfg_os | input | OS_W (5) | Oversampling field, divides by field + 1 |
| div_en | output | 1 | First-stage enable |
| mclk_en | output | 1 | Master-clock enable |
| sclk_en | output | 1 | Shift-clock enable |
| tq_en | output | 1 | Time-quantum enable |
| bit_en | output | 1 | Bit-rate enable |

## Verification
All counters are cleared by a write, so any stuck or mis-wrapping counter shows up as a wrong pulse count on one of the five enables over a window measured from that write. A fault in the first stage shows first: it moves `div_en` within 1024 − step cycles and so corrupts every enable downstream. A fault in a later divider only changes its own enable and the enables after it, and can take (tq+1)·(os+1) source pulses to show at `bit_en`. A missed clear on write shows up as the first pulse arriving early, or as a non-zero enable in the cycle after the write.

// File: rtl/bgen_pkg.sv
// Shared definitions for the fractional baud-rate clock generator.
package bgen_pkg;

    // Time-quantum source selection; codes are fixed by the configuration field.
    typedef enum logic [1:0] {
        SRC_PRESCALED      = 2'd0,
        SRC_DIRECT         = 2'd1,
        SRC_PRESCALED_HALF = 2'd2,
        SRC_MASTER         = 2'd3
    } src_sel_e;

endpackage

// File: rtl/bgen_first_stage.sv
// First divider stage.
// Integer mode: counts up from zero to the bitwise complement of step and
// pulses on that terminal count, which gives a period of 2^W - step clocks.
// Fractional mode: adds step to a W-bit phase accumulator on every clock and
// pulses one cycle after each carry out.
// Assumes: clr wins over counting; the step and mode inputs are stable
// between clears.
module bgen_first_stage #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         frac,
    input  logic [W-1:0] step,
    output logic         pulse
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;
    logic         term;

    assign sum  = {1'b0, acc_q} + {1'b0, step};
    assign term = (acc_q == ~step);

    // Phase accumulator or reload counter, with a registered output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            pulse <= 1'b0;
        end else if (frac) begin
            acc_q <= sum[W-1:0];
            pulse <= sum[W];
        end else begin
            acc_q <= term ? '0 : acc_q + 1'b1;
            pulse <= term;
        end
    end
endmodule

// File: rtl/bgen_modulo.sv
// Enable-driven modulo divider: emits out_en on every (limit+1)-th in_en.
// The output is combinational from in_en and the count state.
// Assumes: clr is asserted whenever limit changes.
module bgen_modulo #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         in_en,
    input  logic [W-1:0] limit,
    output logic         out_en
);
    logic [W-1:0] cnt_q;

    assign out_en = in_en && (cnt_q == limit);

    // Count input pulses and wrap on the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (in_en)
            cnt_q <= out_en ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/frac_baud_gen.sv
// Fractional baud-rate clock generator top.
// Chain: first stage -> optional /2 -> prescaler -> source select ->
// time-quantum divider -> oversampling divider. Side enables: master (first
// stage /2) and shift (prescaler /2).
// Assumes: one clock domain; configuration changes only through cfg_wr.
module frac_baud_gen #(
    parameter int STEP_W = 10,
    parameter int PRE_W  = 10,
    parameter int TQ_W   = 6,
    parameter int OS_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [STEP_W-1:0] cfg_step,
    input  logic              cfg_frac,
    input  logic              cfg_half,
    input  logic [PRE_W-1:0]  cfg_pre,
    input  logic [1:0]        cfg_sel,
    input  logic [TQ_W-1:0]   cfg_tq,
    input  logic [OS_W-1:0]   cfg_os,
    output logic              div_en,
    output logic              mclk_en,
    output logic              sclk_en,
    output logic              tq_en,
    output logic              bit_en
);
    import bgen_pkg::*;

    localparam int NHALF = 3;   // halving stages: after first stage, master, shift

    logic [STEP_W-1:0] cfg_step_q;
    logic              cfg_frac_q;
    logic              cfg_half_q;
    logic [PRE_W-1:0]  cfg_pre_q;
    src_sel_e          cfg_sel_q;
    logic [TQ_W-1:0]   cfg_tq_q;
    logic [OS_W-1:0]   cfg_os_q;

    logic [NHALF-1:0]  half_in;
    logic [NHALF-1:0]  half_out;
    logic              pre_in_en;
    logic              pre_en;
    logic              src_en;

    // Configuration holding registers, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_step_q <= '0;
            cfg_frac_q <= 1'b0;
            cfg_half_q <= 1'b0;
            cfg_pre_q  <= '0;
            cfg_sel_q  <= SRC_PRESCALED;
            cfg_tq_q   <= '0;
            cfg_os_q   <= '0;
        end else if (cfg_wr) begin
            cfg_step_q <= cfg_step;
            cfg_frac_q <= cfg_frac;
            cfg_half_q <= cfg_half;
            cfg_pre_q  <= cfg_pre;
            cfg_sel_q  <= src_sel_e'(cfg_sel);
            cfg_tq_q   <= cfg_tq;
            cfg_os_q   <= cfg_os;
        end
    end

    bgen_first_stage #(.W(STEP_W)) u_first (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_wr),
        .frac  (cfg_frac_q),
        .step  (cfg_step_q),
        .pulse (div_en)
    );

    // The three divide-by-two stages share one structure.
    assign half_in[0] = div_en;
    assign half_in[1] = div_en;
    assign half_in[2] = pre_en;

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        bgen_modulo #(.W(1)) u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (cfg_wr),
            .in_en  (half_in[g]),
            .limit  (1'b1),
            .out_en (half_out[g])
        );
    end

    assign pre_in_en = cfg_half_q ? half_out[0] : div_en;
    assign mclk_en   = half_out[1];
    assign sclk_en   = half_out[2];

    bgen_modulo #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_wr),
        .in_en  (pre_in_en),
        .limit  (cfg_pre_q),
        .out_en (pre_en)
    );

    // Time-quantum source selection.
    always_comb begin
        unique case (cfg_sel_q)
            SRC_PRESCALED:      src_en = pre_en;
            SRC_DIRECT:         src_en = pre_in_en;
            SRC_PRESCALED_HALF: src_en = sclk_en;
            SRC_MASTER:         src_en = mclk_en;
            default:            src_en = 1'b0;
        endcase
    end

    bgen_modulo #(.W(TQ_W)) u_tq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_wr),
        .in_en  (src_en),
        .limit  (cfg_tq_q),
        .out_en (tq_en)
    );

    bgen_modulo #(.W(OS_W)) u_os (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_wr),
        .in_en  (tq_en),
        .limit  (cfg_os_q),
        .out_en (bit_en)
    );
endmodule

// File: rtl/frac_baud_gen_chk.sv
// Property checker for frac_baud_gen; attached by bind below.
// Assumes: the latched mode and step are visible through the bind.
module frac_baud_gen_chk #(
    parameter int STEP_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              frac_q,
    input logic [STEP_W-1:0] step_q,
    input logic              div_en,
    input logic              mclk_en,
    input logic              sclk_en,
    input logic              tq_en,
    input logic              bit_en
);
    a_r8_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !(div_en || mclk_en || sclk_en || tq_en || bit_en));

    a_r10_mclk_in_div: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en |-> div_en);

    a_r10_sclk_in_div: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_en |-> div_en);

    a_r10_tq_in_div: assert property (@(posedge clk) disable iff (!rst_n)
        tq_en |-> div_en);

    a_r7_bit_in_tq: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> tq_en);

    a_r2_zero_step_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_q && step_q == '0) |-> !div_en);

    a_r1_full_step_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!frac_q && step_q == '1 && !cfg_wr && !$past(cfg_wr)) |-> div_en);
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.STEP_W(STEP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .frac_q  (cfg_frac_q),
    .step_q  (cfg_step_q),
    .div_en  (div_en),
    .mclk_en (mclk_en),
    .sclk_en (sclk_en),
    .tq_en   (tq_en),
    .bit_en  (bit_en)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [9:0] cfg_step = '0;
    logic       cfg_frac = 1'b0;
    logic       cfg_half = 1'b0;
    logic [9:0] cfg_pre = '0;
    logic [1:0] cfg_sel = '0;
    logic [5:0] cfg_tq = '0;
    logic [4:0] cfg_os = '0;
    logic div_en, mclk_en, sclk_en, tq_en, bit_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    frac_baud_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_step(cfg_step),
        .cfg_frac(cfg_frac), .cfg_half(cfg_half), .cfg_pre(cfg_pre),
        .cfg_sel(cfg_sel), .cfg_tq(cfg_tq), .cfg_os(cfg_os),
        .div_en(div_en), .mclk_en(mclk_en), .sclk_en(sclk_en),
        .tq_en(tq_en), .bit_en(bit_en)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a configuration write at a falling edge; return at the next
    // falling edge (the cycle after the write edge) and check it is quiet.
    task automatic write_cfg(int step, bit frac, bit half, int pre, int sel, int tq, int os);
        @(negedge clk);
        cfg_step = 10'(step); cfg_frac = frac; cfg_half = half;
        cfg_pre = 10'(pre); cfg_sel = 2'(sel); cfg_tq = 6'(tq); cfg_os = 5'(os);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R8 quiet after write", int'({div_en, mclk_en, sclk_en, tq_en, bit_en}), 0);
    endtask

    // Count each enable over w edges, and note the first div_en cycle.
    task automatic run_and_check(int w, int step, bit frac, bit half, int pre, int sel, int tq, int os);
        int cd = 0, cm = 0, cs = 0, ct = 0, cb = 0, first = 0;
        int f, h, m, pd, s, src, t, b;
        for (int k = 1; k <= w; k++) begin
            @(negedge clk);
            if (div_en && cd == 0) first = k;
            cd += int'(div_en); cm += int'(mclk_en); cs += int'(sclk_en);
            ct += int'(tq_en);  cb += int'(bit_en);
        end
        f  = frac ? (w * step) / 1024 : w / (1024 - step);
        h  = half ? f / 2 : f;
        m  = f / 2;
        pd = h / (pre + 1);
        s  = pd / 2;
        case (sel)
            0: src = pd;
            1: src = h;
            2: src = s;
            default: src = m;
        endcase
        t = src / (tq + 1);
        b = t / (os + 1);
        if (frac) chk("R2 div_en count", cd, f);
        else begin
            chk("R1 div_en count", cd, f);
            chk("R1 first pulse cycle", first, (f > 0) ? 1024 - step : 0);
        end
        chk("R5 mclk_en count", cm, m);
        chk(half ? "R3 sclk_en count (halved input)" : "R4 sclk_en count", cs, s);
        chk("R6 tq_en count", ct, t);
        chk("R7 bit_en count", cb, b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R9: reset state and default configuration.
        repeat (4) @(negedge clk);
        chk("R9 outputs low in reset", int'({div_en, mclk_en, sclk_en, tq_en, bit_en}), 0);
        rst_n = 1'b1;
        run_and_check(2100, 0, 1'b0, 1'b0, 0, 0, 0, 0);

        // Directed corners.
        write_cfg(1023, 1'b0, 1'b0, 0, 0, 0, 0);       // R1 every cycle
        run_and_check(300, 1023, 1'b0, 1'b0, 0, 0, 0, 0);
        write_cfg(0, 1'b1, 1'b1, 0, 3, 0, 0);          // R2 step 0 silent
        run_and_check(2000, 0, 1'b1, 1'b1, 0, 3, 0, 0);
        write_cfg(512, 1'b1, 1'b1, 2, 1, 1, 2);        // R2/R3/R6 half rate
        run_and_check(3000, 512, 1'b1, 1'b1, 2, 1, 1, 2);
        write_cfg(0, 1'b0, 1'b0, 1, 2, 0, 1);          // R1 slowest rate
        run_and_check(2100, 0, 1'b0, 1'b0, 1, 2, 0, 1);
        write_cfg(1013, 1'b0, 1'b0, 3, 0, 2, 1);       // R8 rewrite mid-run
        repeat (37) @(negedge clk);
        write_cfg(1013, 1'b0, 1'b0, 3, 0, 2, 1);
        run_and_check(1500, 1013, 1'b0, 1'b0, 3, 0, 2, 1);

        // Constrained random configurations.
        for (int i = 0; i < 16; i++) begin
            bit fr = 1'($urandom % 2);
            int st = fr ? 256 + int'($urandom % 768) : 1000 + int'($urandom % 24);
            bit hf = 1'($urandom % 2);
            int pr = int'($urandom % 4);
            int sl = int'($urandom % 4);
            int tq = int'($urandom % 4);
            int os = int'($urandom % 4);
            write_cfg(st, fr, hf, pr, sl, tq, os);
            run_and_check(4000, st, fr, hf, pr, sl, tq, os);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule